// File: doc/BRIEF.md
# Stepwise I2C Bus Master

This block is an I2C master that software drives one protocol step at a time through a small register window. A step is one of five things: a START, a repeated START, the address byte, a data byte (sent or received), or a STOP. After every step except STOP, the block loads a fixed byte code into its status register and sets an interrupt flag. It then holds SCL low until software writes that flag back to zero, and only then does it perform the next step.

The bus pins are open drain. Each line has an output enable that pulls it low, plus an input that reads the resolved line level. The bit rate comes from a two-factor divider.

Received bytes are acknowledged or refused according to a control bit, not according to a byte count. Software therefore decides the ACK for each byte before it releases the bus for that byte.

Top module: `i2c_step_master`

## Requirements
- R1: After reset both output enables are low, `irq` is low, the control register (offset 0x0C) reads 0x00 and the status register (offset 0x10) reads the idle code 0xF8.
- R2: With bus enable (control bit 6) set and the interrupt flag (control bit 3) clear, setting START (control bit 5) while idle drives a START condition. The block then clears the START bit, sets the flag and reports status 0x08.
- R3: While the flag is set, SCL stays low and neither line changes. Writing 1 to the flag bit leaves it set; only writing 0 lets the next step begin.
- R4: The first byte after a START or repeated START is the data register (offset 0x08), sent MSB first. Bit 0 selects read (1) or write (0). The status becomes 0x18 or 0x20 for a write address that was ACKed or NAKed, and 0x40 or 0x48 for a read address that was ACKed or NAKed.
- R5: In a write phase, releasing the flag sends the data register MSB first, with SDA changing only while SCL is low. The ninth-clock acknowledge is then sampled and the status becomes 0x28 (ACK) or 0x30 (NAK).
- R6: In a read phase, releasing the flag shifts eight bits into the data register. On the ninth clock the block drives ACK (SDA low) if control bit 2 is set and NAK if it is clear, and reports 0x50 or 0x58 to match.
- R7: Setting START while the bus is held mid-transfer produces a repeated START and status 0x10.
- R8: Setting STOP (control bit 4) while the bus is held drives a STOP condition. The block then clears the STOP bit, releases both lines, returns to idle with status 0xF8 and does not set the flag.
- R9: `irq` is high exactly when the flag and interrupt enable (control bit 7) are both set.
- R10: While bus enable is clear, a START request causes no line activity and no flag.
- R11: Writing 1 to bit 0 at offset 0x18 returns the block to idle. It releases both lines, clears the flag and the START and STOP bits, and sets the status to 0xF8. The next START reports 0x08, not 0x10.
- R12: The clock control register (offset 0x14) holds N in bits 2:0 and M in bits 6:3. SCL is high for 2·(M+1)·2^N clock cycles in every bit.
- R13: If SDA changes while SCL is high during a bit, the block releases both lines and returns to idle. It sets the flag and reports status 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low when high |
| scl_in | input | 1 | Resolved SCL level |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | Resolved SDA level |

## Verification
The bus-error path is the hardest state to reach from the ports. A well-behaved target never moves SDA while SCL is high, so the path needs a disturbance timed inside the high half of one specific bit.

The bench slows the divider so that each phase lasts four cycles. It arms a one-shot disturbance on the third SCL rise of a received byte and inverts the target's data drive six cycles later. That places the edge between the two SDA samples the block takes during that high period.

A following START then shows that the block has really returned to idle.

// File: rtl/i2c_step_master.sv
module i2c_step_master #(
  parameter int         AW        = 5,
  parameter logic [7:0] IDLE_CODE = 8'hF8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  output logic          scl_oe,
  input  logic          scl_in,
  output logic          sda_oe,
  input  logic          sda_in
);
  localparam logic [AW-1:0] A_SAD = AW'(8'h00);
  localparam logic [AW-1:0] A_XAD = AW'(8'h04);
  localparam logic [AW-1:0] A_DAT = AW'(8'h08);
  localparam logic [AW-1:0] A_CTL = AW'(8'h0C);
  localparam logic [AW-1:0] A_STS = AW'(8'h10);
  localparam logic [AW-1:0] A_CLK = AW'(8'h14);
  localparam logic [AW-1:0] A_RST = AW'(8'h18);
  localparam int            TW    = 12;

  typedef enum logic [2:0] {S_IDLE, S_START, S_RSTART, S_BIT, S_HOLD, S_STOP} state_t;

  state_t          st;
  logic [1:0]      ph;
  logic [3:0]      bcnt;
  logic [7:0]      sad, xad, dat, sh, stat;
  logic [6:0]      ccr;
  logic            ack_en, flag, stop_rq, start_rq, bus_en, int_en;
  logic            is_addr, rx, rdm, ackq, s1, sbit;
  logic [TW-1:0]   tcnt, tlim;
  logic            run, tick;

  assign tlim = ((TW'(ccr[6:3]) + TW'(1)) << ccr[2:0]) - TW'(1);
  assign run  = (st != S_IDLE) && (st != S_HOLD);
  assign tick = run && (tcnt == tlim);
  assign irq  = flag & int_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               tcnt <= '0;
    else if (!run || tick)    tcnt <= '0;
    else                      tcnt <= tcnt + TW'(1);

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START:  begin scl_oe = (ph == 2'd2); sda_oe = (ph != 2'd0); end
      S_RSTART: begin scl_oe = (ph == 2'd0) || (ph == 2'd3); sda_oe = ph[1]; end
      S_STOP:   begin scl_oe = (ph == 2'd0); sda_oe = !ph[1]; end
      S_BIT: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
        if (bcnt == 4'd8) sda_oe = rx && ackq;
        else              sda_oe = !rx && !sh[7];
      end
      S_HOLD:   scl_oe = 1'b1;
      default:  ;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_SAD:   reg_rdata = sad;
      A_XAD:   reg_rdata = xad;
      A_DAT:   reg_rdata = dat;
      A_CTL:   reg_rdata = {int_en, bus_en, start_rq, stop_rq, flag, ack_en, 2'b00};
      A_STS:   reg_rdata = stat;
      A_CLK:   reg_rdata = {1'b0, ccr};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; bcnt <= '0;
      sad <= '0; xad <= '0; dat <= '0; sh <= '0; stat <= IDLE_CODE; ccr <= '0;
      ack_en <= 1'b0; flag <= 1'b0; stop_rq <= 1'b0; start_rq <= 1'b0;
      bus_en <= 1'b0; int_en <= 1'b0;
      is_addr <= 1'b0; rx <= 1'b0; rdm <= 1'b0; ackq <= 1'b0; s1 <= 1'b1; sbit <= 1'b1;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          A_SAD: sad <= reg_wdata;
          A_XAD: xad <= reg_wdata;
          A_DAT: dat <= reg_wdata;
          A_CTL: begin
            ack_en   <= reg_wdata[2];
            flag     <= flag & reg_wdata[3];
            stop_rq  <= reg_wdata[4];
            start_rq <= reg_wdata[5];
            bus_en   <= reg_wdata[6];
            int_en   <= reg_wdata[7];
          end
          A_CLK: ccr <= reg_wdata[6:0];
          default: ;
        endcase
      end

      case (st)
        S_IDLE:
          if (bus_en && start_rq && !flag) begin st <= S_START; ph <= '0; end
        S_HOLD:
          if (!flag) begin
            ph   <= '0;
            bcnt <= '0;
            if (stop_rq)       st <= S_STOP;
            else if (start_rq) st <= S_RSTART;
            else begin
              st   <= S_BIT;
              rx   <= !is_addr && rdm;
              sh   <= dat;
              ackq <= ack_en;
              if (is_addr) rdm <= dat[0];
            end
          end
        S_START:
          if (tick) begin
            if (ph == 2'd2) begin
              st <= S_HOLD; stat <= 8'h08; flag <= 1'b1; start_rq <= 1'b0; is_addr <= 1'b1;
            end else ph <= ph + 2'd1;
          end
        S_RSTART:
          if (tick) begin
            if (ph == 2'd3) begin
              st <= S_HOLD; stat <= 8'h10; flag <= 1'b1; start_rq <= 1'b0; is_addr <= 1'b1;
            end else ph <= ph + 2'd1;
          end
        S_STOP:
          if (tick) begin
            if (ph == 2'd2) begin
              st <= S_IDLE; stop_rq <= 1'b0; stat <= IDLE_CODE;
            end else ph <= ph + 2'd1;
          end
        S_BIT:
          if (tick) begin
            ph <= ph + 2'd1;
            if (ph == 2'd1) s1 <= sda_in;
            if (ph == 2'd2) begin
              sbit <= sda_in;
              if (scl_in && (sda_in != s1)) begin
                st <= S_IDLE; stat <= 8'h00; flag <= 1'b1;
                start_rq <= 1'b0; stop_rq <= 1'b0;
              end
            end
            if (ph == 2'd3) begin
              if (bcnt == 4'd8) begin
                st <= S_HOLD; flag <= 1'b1; is_addr <= 1'b0;
                if (is_addr)   stat <= rdm ? (sbit ? 8'h48 : 8'h40) : (sbit ? 8'h20 : 8'h18);
                else if (rx) begin dat <= sh; stat <= ackq ? 8'h50 : 8'h58; end
                else           stat <= sbit ? 8'h30 : 8'h28;
              end else begin
                sh   <= {sh[6:0], sbit};
                bcnt <= bcnt + 4'd1;
              end
            end
          end
        default: st <= S_IDLE;
      endcase

      if (reg_we && (reg_addr == A_RST) && reg_wdata[0]) begin
        st <= S_IDLE; ph <= '0; bcnt <= '0; flag <= 1'b0;
        start_rq <= 1'b0; stop_rq <= 1'b0; stat <= IDLE_CODE; is_addr <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_step_master_chk.sv
module i2c_step_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       flag,
  input logic       bus_en,
  input logic       start_rq,
  input logic       in_idle,
  input logic       in_bit,
  input logic [7:0] stat
);
  // R3
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && $past(flag) |-> $stable(scl_oe) && $stable(sda_oe));

  // R3
  step_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) && (stat != 8'h00) |-> scl_oe);

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) && (stat == 8'h08) |-> !start_rq);

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && !bus_en |=> !scl_oe && !sda_oe);

  // R5
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_bit && $past(in_bit) && !scl_oe && !$past(scl_oe) |-> $stable(sda_oe));

  // R4
  code_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> (stat[2:0] == 3'b000) && (stat != 8'hF8));
endmodule

bind i2c_step_master i2c_step_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .flag(flag),
  .bus_en(bus_en), .start_rq(start_rq), .in_idle(st == S_IDLE),
  .in_bit(st == S_BIT), .stat(stat)
);

// File: tb/i2c_step_master_bench.sv
module i2c_step_master_bench;
  localparam int CLK_NS = 10;
  localparam logic [4:0] R_DAT = 5'h08, R_CTL = 5'h0C, R_STS = 5'h10, R_CLK = 5'h14, R_RST = 5'h18;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  wire  [7:0] reg_rdata;
  wire  irq, scl_oe, sda_oe;
  logic slv_pull;
  wire  scl_line = !scl_oe;
  wire  sda_line = !(sda_oe || slv_pull);

  int n_chk = 0, n_fail = 0;
  int rises = 0, falls = 0, rbase = 0, fbase = 0, mode = 0, hi_len = 0;
  logic [7:0] cap = '0, rx_byte = '0;
  logic ack_seen = 1'b1, ack_plan = 1'b0, glitch = 1'b0, glitch_arm = 1'b0;
  time t_rise = 0;

  always #(CLK_NS/2) clk = ~clk;

  i2c_step_master u_i2c_step_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .scl_oe(scl_oe), .scl_in(scl_line),
    .sda_oe(sda_oe), .sda_in(sda_line)
  );

  always @(posedge scl_line) begin
    if (rises - rbase < 8) cap = {cap[6:0], sda_line};
    else if (rises - rbase == 8) ack_seen = sda_line;
    rises = rises + 1;
    t_rise = $time;
  end

  always @(negedge scl_line) begin
    falls = falls + 1;
    hi_len = int'(($time - t_rise) / CLK_NS);
  end

  always @(posedge scl_line)
    if (glitch_arm && (falls - fbase == 2)) begin
      repeat (6) @(posedge clk);
      glitch = 1'b1;
      repeat (20) @(posedge clk);
      glitch = 1'b0;
    end

  always_comb begin
    int k;
    k = falls - fbase;
    case (mode)
      1:       slv_pull = ack_plan && (k == 8);
      2:       slv_pull = ((k >= 0 && k < 8) ? !rx_byte[3'(7 - k)] : 1'b0) ^ glitch;
      default: slv_pull = 1'b0;
    endcase
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] ctl(input bit ien, input bit sta, input bit sto, input bit flg, input bit ack);
    return {ien, 1'b1, sta, sto, flg, ack, 2'b00};
  endfunction

  function automatic logic [7:0] exp_code(input int kind, input bit rdir, input bit ack);
    if (kind == 0) return rdir ? (ack ? 8'h40 : 8'h48) : (ack ? 8'h18 : 8'h20);
    if (kind == 1) return ack ? 8'h28 : 8'h30;
    return ack ? 8'h50 : 8'h58;
  endfunction

  function automatic int exp_high(input logic [6:0] c);
    return 2 * ((int'(c[6:3]) + 1) << c[2:0]);
  endfunction

  task automatic wait_flag(input string req);
    logic [7:0] c;
    bit ok;
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      rd(R_CTL, c);
      if (c[3]) begin ok = 1'b1; break; end
    end
    chk(req, "flag raised", int'(ok), 1);
  endtask

  task automatic do_start(input bit rep, input string req);
    logic [7:0] v;
    mode = 0;
    wr(R_CTL, ctl(1, 1, 0, 0, 1));
    wait_flag(req);
    rd(R_STS, v); chk(req, "start status", v, rep ? 8'h10 : 8'h08);
    rd(R_CTL, v); chk(req, "start bit self-cleared", v[5], 0);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit ack, input bit is_addr, input logic [6:0] cc);
    logic [7:0] v;
    wr(R_DAT, b);
    mode = 1; ack_plan = ack; rbase = rises; fbase = falls;
    wr(R_CTL, ctl(1, 0, 0, 0, 1));
    wait_flag(is_addr ? "R4" : "R5");
    rd(R_STS, v);
    if (is_addr) begin
      chk("R4", "address bits on bus", cap, b);
      chk("R4", "address status", v, exp_code(0, b[0], ack));
    end else begin
      chk("R5", "data bits on bus", cap, b);
      chk("R5", "write status", v, exp_code(1, 0, ack));
      chk("R12", "SCL high length", hi_len, exp_high(cc));
    end
  endtask

  task automatic recv_byte(input logic [7:0] b, input bit ack);
    logic [7:0] v;
    mode = 2; rx_byte = b; rbase = rises; fbase = falls;
    wr(R_CTL, ctl(1, 0, 0, 0, ack));
    wait_flag("R6");
    rd(R_DAT, v); chk("R6", "received byte", v, b);
    chk("R6", "ninth-bit level", ack_seen, !ack);
    rd(R_STS, v); chk("R6", "read status", v, exp_code(2, 1, ack));
  endtask

  task automatic do_stop();
    logic [7:0] v;
    mode = 0;
    wr(R_CTL, ctl(1, 0, 1, 0, 1));
    for (int i = 0; i < 2000; i++) begin
      rd(R_CTL, v);
      if (!v[4]) break;
    end
    repeat (2) @(negedge clk);
    chk("R8", "lines released", {scl_oe, sda_oe}, 0);
    rd(R_CTL, v); chk("R8", "stop clear, no flag", {v[4], v[3]}, 0);
    rd(R_STS, v); chk("R8", "idle status", v, 8'hF8);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [6:0] cc;
    int f0;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "lines and irq", {scl_oe, sda_oe, irq}, 0);
    rd(R_CTL, v); chk("R1", "control", v, 0);
    rd(R_STS, v); chk("R1", "status", v, 8'hF8);

    // R10 disabled bus ignores START
    f0 = falls;
    wr(R_CTL, 8'hA0);
    repeat (40) @(negedge clk);
    chk("R10", "no line activity", {scl_oe, sda_oe}, 0);
    chk("R10", "no SCL edges", falls - f0, 0);
    rd(R_CTL, v); chk("R10", "no flag", v[3], 0);
    wr(R_CTL, 8'h00);

    // R12 slow divider, directed write
    cc = 7'h11;
    wr(R_CLK, {1'b0, cc});
    do_start(0, "R2");
    f0 = falls;
    repeat (40) @(negedge clk);
    chk("R3", "SCL held low", scl_oe, 1);
    chk("R3", "no clocks while held", falls - f0, 0);
    wr(R_CTL, ctl(1, 0, 0, 1, 1));
    repeat (20) @(negedge clk);
    rd(R_CTL, v); chk("R3", "writing 1 keeps flag", v[3], 1);
    chk("R3", "still held", falls - f0, 0);
    wr(R_CTL, ctl(0, 0, 0, 1, 1));
    chk("R9", "irq masked", irq, 0);
    wr(R_CTL, ctl(1, 0, 0, 1, 1));
    chk("R9", "irq enabled", irq, 1);
    send_byte({7'h2A, 1'b0}, 1, 1, cc);
    send_byte(8'hC3, 0, 0, cc);
    do_start(1, "R7");
    send_byte({7'h2A, 1'b1}, 1, 1, cc);
    recv_byte(8'h96, 1);
    recv_byte(8'h5A, 0);
    do_stop();
    chk("R9", "irq low after stop", irq, 0);

    // R11 soft reset from a held bus
    do_start(0, "R2");
    wr(R_RST, 8'h01);
    repeat (3) @(negedge clk);
    chk("R11", "lines released", {scl_oe, sda_oe}, 0);
    rd(R_STS, v); chk("R11", "idle status", v, 8'hF8);
    rd(R_CTL, v); chk("R11", "flag cleared", v[3], 0);
    do_start(0, "R11");
    do_stop();

    // R13 disturbance during a received bit
    cc = 7'h18;
    wr(R_CLK, {1'b0, cc});
    do_start(0, "R2");
    send_byte({7'h55, 1'b1}, 1, 1, cc);
    mode = 2; rx_byte = 8'hF0; rbase = rises; fbase = falls;
    glitch_arm = 1'b1;
    wr(R_CTL, ctl(1, 0, 0, 0, 1));
    wait_flag("R13");
    glitch_arm = 1'b0;
    mode = 0;
    rd(R_STS, v); chk("R13", "bus error status", v, 8'h00);
    chk("R13", "lines released", {scl_oe, sda_oe}, 0);
    repeat (30) @(negedge clk);
    wr(R_CTL, ctl(1, 0, 0, 0, 1));
    do_start(0, "R13");
    do_stop();

    // random transactions
    for (int t = 0; t < 10; t++) begin
      bit rdir, rep;
      int nb;
      cc = {3'($urandom % 4), 1'b0, 3'($urandom % 2)};
      cc[6:3] = 4'($urandom % 4);
      wr(R_CLK, {1'b0, cc});
      rdir = 1'($urandom % 2);
      do_start(0, "R2");
      send_byte({7'($urandom), rdir}, 1'($urandom % 2), 1, cc);
      nb = 1 + int'($urandom % 3);
      for (int j = 0; j < nb; j++) begin
        if (rdir) recv_byte(8'($urandom), 1'($urandom % 2));
        else      send_byte(8'($urandom), 1'($urandom % 2), 0, cc);
      end
      rep = 1'($urandom % 2);
      if (rep) begin
        do_start(1, "R7");
        send_byte({7'($urandom), 1'b0}, 1, 1, cc);
        send_byte(8'($urandom), 1, 0, cc);
      end
      do_stop();
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule